// File: doc/BRIEF.md
# Dual-Window Triggered Trace Capture

This block records two waveforms from one stream of 14-bit converter samples. Both are kept in circular stores that fill without pause until a trigger comes. The long "energy" window keeps one sample in four. The short "shape" window keeps every sample. Each window has its own length and its own post-trigger delay, counted in clock ticks. After the trigger, a window goes on filling for its delay and then freezes. Once every enabled window is frozen, a valid/ready read port streams the stored samples out as 16-bit words. The energy window comes first and the shape window second, each oldest first.

A single controller state machine sequences the capture. Its states are `CAP_FILL` (both windows filling, waiting for a trigger), `CAP_POST` (post-trigger delays running), `CAP_READ_E` (energy words out) and `CAP_READ_S` (shape words out). Its transitions are:
- *accept*: `CAP_FILL`→`CAP_POST` on a trigger.
- *all frozen*: `CAP_POST`→`CAP_READ_E` once the energy window is frozen and the shape window is either frozen or disabled.
- *next window*: `CAP_READ_E`→`CAP_READ_S` when the last energy word is taken and the shape window is enabled.
- *done*: `CAP_READ_E`→`CAP_FILL` when the last energy word is taken and the shape window is disabled, or `CAP_READ_S`→`CAP_FILL` when the last shape word is taken.

Each window also runs a small state machine of its own: `WIN_RUN`, `WIN_ARMED` and `WIN_HELD`. The arm step loads the delay count. The freeze step happens when the count is zero. The return to `WIN_RUN` happens on release by the controller.

Top module: `trace_capture_dual`

## Requirements
- R1: The energy window keeps a valid sample only when its index among the valid samples since reset is a multiple of 4; the first valid sample after reset is kept. The window holds the most recent `cfg_e_len` kept samples, where `cfg_e_len` is between 1 and 1024.
- R2: The shape window keeps every valid sample and holds the most recent `cfg_s_len` of them, where `cfg_s_len` is between 1 and 512.
- R3: Let a trigger be accepted at clock edge t in `CAP_FILL`, and let D be a window's delay. That window stores the qualifying samples presented at edges t through t+D and no later sample; D=0 stores up to edge t only.
- R4: When D spans more kept samples than the window length, the window holds only the last length-many samples up to edge t+D.
- R5: The read port presents the energy window first, with `rd_win`=0, and then the shape window, with `rd_win`=1. Within each window, words come oldest first. `rd_last`=1 on the final word of each window, and a word is taken on a clock edge where `rd_valid` and `rd_ready` are both high.
- R6: `rd_data[13:0]` carries the stored sample and `rd_data[15:14]` is zero.
- R7: When `cfg_s_en`=0, only the energy words are presented, and the block returns to `CAP_FILL` on the edge that takes the last energy word.
- R8: `busy` is high from the cycle after an accepted trigger until the edge that takes the last word. A trigger while `busy` is high changes neither the data read out nor the return to idle.
- R9: While `rd_valid`=1 and `rd_ready`=0, `rd_data`, `rd_win` and `rd_last` hold their values.
- R10: After reset, `busy`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per delay unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Converter sample |
| trig | input | 1 | Trigger, sampled each clock edge |
| cfg_e_len | input | 11 | Energy window length in kept samples |
| cfg_s_len | input | 10 | Shape window length in samples |
| cfg_e_delay | input | 16 | Energy post-trigger delay in ticks |
| cfg_s_delay | input | 16 | Shape post-trigger delay in ticks |
| cfg_s_en | input | 1 | Enable for the shape window |
| busy | output | 1 | Capture or readout in progress |
| rd_valid | output | 1 | A stored word is offered |
| rd_ready | input | 1 | Consumer takes the offered word |
| rd_data | output | 16 | Zero-extended stored sample |
| rd_win | output | 1 | 0 for energy words, 1 for shape words |
| rd_last | output | 1 | Final word of the current window |

## Verification
The assertions take for granted that the four configuration inputs and the shape enable stay constant while `busy` is high, and that each length lies within its store depth. Under those conditions the read counter never passes the window length, and a frozen window's write pointer stands still. The stimulus changes configuration only at idle, before the pre-trigger fill. That fill always supplies more than a full window of samples since the last release, so no slot is read before it has been written.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

    // Controller sequence for one capture and readout
    typedef enum logic [1:0] {
        CAP_FILL,
        CAP_POST,
        CAP_READ_E,
        CAP_READ_S
    } cap_state_t;

    // Per-window life cycle
    typedef enum logic [1:0] {
        WIN_RUN,
        WIN_ARMED,
        WIN_HELD
    } win_state_t;

endpackage

// File: rtl/trace_window.sv
module trace_window
    import trace_cap_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int RATIO    = 1,
    parameter int SAMPLE_W = 14,
    parameter int DELAY_W  = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LW-1:0]       cfg_len,
    input  logic [DELAY_W-1:0]  cfg_delay,
    input  logic                start,
    input  logic                rel_i,
    input  logic                rd_adv,
    output logic                frozen,
    output logic [SAMPLE_W-1:0] rd_sample,
    output logic                rd_last
);

    win_state_t           st;
    logic [DELAY_W-1:0]   cnt;
    logic [AW-1:0]        wp;
    logic [AW-1:0]        rp;
    logic [AW-1:0]        rcnt;
    logic [AW-1:0]        last_idx;
    logic [LW-1:0]        len_eff;
    logic [PW-1:0]        phase;
    logic                 keep;
    logic                 we;
    logic [SAMPLE_W-1:0]  mem [DEPTH];

    // Clamp the programmed length into 1..DEPTH
    always_comb begin
        if (cfg_len == '0) begin
            len_eff = LW'(1);
        end else if (cfg_len > LW'(DEPTH)) begin
            len_eff = LW'(DEPTH);
        end else begin
            len_eff = cfg_len;
        end
    end

    assign last_idx = AW'(len_eff - LW'(1));

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p,
                                               input logic [AW-1:0] lim);
        return (p >= lim) ? '0 : p + AW'(1);
    endfunction

    // Decimation phase runs on every valid sample, frozen or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (smp_valid) begin
            phase <= (phase >= PW'(RATIO - 1)) ? '0 : phase + PW'(1);
        end
    end

    assign keep = smp_valid && (phase == '0);

    // Write permission follows the window state
    always_comb begin
        unique case (st)
            WIN_RUN:   we = keep;
            WIN_ARMED: we = keep && (cnt != '0) && !rel_i;
            default:   we = 1'b0;
        endcase
    end

    // State register with pointers and the delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= WIN_RUN;
            cnt  <= '0;
            wp   <= '0;
            rp   <= '0;
            rcnt <= '0;
        end else begin
            if (we) begin
                wp <= wrap_inc(wp, last_idx);
            end
            unique case (st)
                WIN_RUN: begin
                    if (start) begin
                        st  <= WIN_ARMED;
                        cnt <= cfg_delay;
                    end
                end
                WIN_ARMED: begin
                    if (rel_i) begin
                        st <= WIN_RUN;
                    end else if (cnt == '0) begin
                        st   <= WIN_HELD;
                        rp   <= wp;
                        rcnt <= '0;
                    end else begin
                        cnt <= cnt - DELAY_W'(1);
                    end
                end
                WIN_HELD: begin
                    if (rel_i) begin
                        st <= WIN_RUN;
                    end else if (rd_adv) begin
                        rp   <= wrap_inc(rp, last_idx);
                        rcnt <= rcnt + AW'(1);
                    end
                end
                default: st <= WIN_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wp] <= smp_data;
        end
    end

    // Outputs
    always_comb begin
        frozen    = (st == WIN_HELD);
        rd_sample = mem[rp];
        rd_last   = (rcnt == last_idx);
    end

    // A frozen window never moves its write pointer
    assert_wp_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WIN_HELD && !rel_i) |=> $stable(wp));

    // The read count never runs past the window length
    assert_rd_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WIN_HELD) |-> (rcnt <= last_idx));

endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trace_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic s_en,
    input  logic e_frozen,
    input  logic s_frozen,
    input  logic e_last,
    input  logic s_last,
    input  logic rd_ready,
    output logic start,
    output logic rel,
    output logic busy,
    output logic rd_valid,
    output logic rd_win,
    output logic e_adv,
    output logic s_adv
);

    cap_state_t st;
    cap_state_t st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= CAP_FILL;
        end else begin
            st <= st_n;
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            CAP_FILL:   if (trig) st_n = CAP_POST;
            CAP_POST:   if (e_frozen && (s_frozen || !s_en)) st_n = CAP_READ_E;
            CAP_READ_E: if (rd_ready && e_last) st_n = s_en ? CAP_READ_S : CAP_FILL;
            CAP_READ_S: if (rd_ready && s_last) st_n = CAP_FILL;
            default:    st_n = CAP_FILL;
        endcase
    end

    always_comb begin
        start    = 1'b0;
        rel      = 1'b0;
        busy     = 1'b1;
        rd_valid = 1'b0;
        rd_win   = 1'b0;
        e_adv    = 1'b0;
        s_adv    = 1'b0;
        unique case (st)
            CAP_FILL: begin
                busy  = 1'b0;
                start = trig;
            end
            CAP_POST: begin
            end
            CAP_READ_E: begin
                rd_valid = 1'b1;
                e_adv    = rd_ready && !e_last;
                rel      = rd_ready && e_last && !s_en;
            end
            CAP_READ_S: begin
                rd_valid = 1'b1;
                rd_win   = 1'b1;
                s_adv    = rd_ready && !s_last;
                rel      = rd_ready && s_last;
            end
            default: begin
            end
        endcase
    end

    // Post-trigger phase always leads into a readout, never straight to idle
    assert_post_no_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_POST) |=> (st != CAP_FILL));

    // Shape readout only happens with the shape window enabled
    assert_disabled_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_READ_S) |-> s_en);

    // Last energy word hands over to the shape window when enabled
    assert_last_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_READ_E && rd_ready && e_last && s_en) |=> (st == CAP_READ_S));

endmodule

// File: rtl/trace_capture_dual.sv
module trace_capture_dual
    import trace_cap_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int WORD_W   = 16,
    parameter int E_DEPTH  = 1024,
    parameter int S_DEPTH  = 512,
    parameter int E_RATIO  = 4,
    parameter int DELAY_W  = 16,
    localparam int E_LW = $clog2(E_DEPTH + 1),
    localparam int S_LW = $clog2(S_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                trig,
    input  logic [E_LW-1:0]     cfg_e_len,
    input  logic [S_LW-1:0]     cfg_s_len,
    input  logic [DELAY_W-1:0]  cfg_e_delay,
    input  logic [DELAY_W-1:0]  cfg_s_delay,
    input  logic                cfg_s_en,
    output logic                busy,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_win,
    output logic                rd_last
);

    logic                start;
    logic                rel;
    logic                e_frozen;
    logic                s_frozen;
    logic                e_last;
    logic                s_last;
    logic                e_adv;
    logic                s_adv;
    logic [SAMPLE_W-1:0] e_sample;
    logic [SAMPLE_W-1:0] s_sample;

    trace_capture_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .s_en     (cfg_s_en),
        .e_frozen (e_frozen),
        .s_frozen (s_frozen),
        .e_last   (e_last),
        .s_last   (s_last),
        .rd_ready (rd_ready),
        .start    (start),
        .rel      (rel),
        .busy     (busy),
        .rd_valid (rd_valid),
        .rd_win   (rd_win),
        .e_adv    (e_adv),
        .s_adv    (s_adv)
    );

    trace_window #(
        .DEPTH    (E_DEPTH),
        .RATIO    (E_RATIO),
        .SAMPLE_W (SAMPLE_W),
        .DELAY_W  (DELAY_W)
    ) u_energy (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cfg_len   (cfg_e_len),
        .cfg_delay (cfg_e_delay),
        .start     (start),
        .rel_i     (rel),
        .rd_adv    (e_adv),
        .frozen    (e_frozen),
        .rd_sample (e_sample),
        .rd_last   (e_last)
    );

    trace_window #(
        .DEPTH    (S_DEPTH),
        .RATIO    (1),
        .SAMPLE_W (SAMPLE_W),
        .DELAY_W  (DELAY_W)
    ) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cfg_len   (cfg_s_len),
        .cfg_delay (cfg_s_delay),
        .start     (start),
        .rel_i     (rel),
        .rd_adv    (s_adv),
        .frozen    (s_frozen),
        .rd_sample (s_sample),
        .rd_last   (s_last)
    );

    always_comb begin
        rd_data = WORD_W'(rd_win ? s_sample : e_sample);
        rd_last = rd_valid && (rd_win ? s_last : e_last);
    end

    // An offered word stays put until it is taken
    assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_win)
                                     && $stable(rd_last)));

endmodule

// File: tb/test_trace_capture_dual.sv
`timescale 1ns/1ps
module test_trace_capture_dual;

    localparam int RING = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_data = '0;
    logic        trig = 1'b0;
    logic [10:0] cfg_e_len = 11'd16;
    logic [9:0]  cfg_s_len = 10'd8;
    logic [15:0] cfg_e_delay = '0;
    logic [15:0] cfg_s_delay = '0;
    logic        cfg_s_en = 1'b1;
    logic        rd_ready = 1'b0;
    logic        busy;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        rd_win;
    logic        rd_last;

    int nchk = 0;
    int nfail = 0;
    int edge_n = 0;
    int vcnt = 0;
    int trig_edge = 0;
    bit trig_real = 1'b0;
    bit gap_mode = 1'b0;

    logic        hv [RING];
    logic        hk [RING];
    logic [13:0] hd [RING];
    logic [13:0] exp_e [1024];
    logic [13:0] exp_s [512];

    always #2.5 clk = ~clk;

    trace_capture_dual i_trace_capture_dual (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .trig        (trig),
        .cfg_e_len   (cfg_e_len),
        .cfg_s_len   (cfg_s_len),
        .cfg_e_delay (cfg_e_delay),
        .cfg_s_delay (cfg_s_delay),
        .cfg_s_en    (cfg_s_en),
        .busy        (busy),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .rd_win      (rd_win),
        .rd_last     (rd_last)
    );

    function automatic logic [13:0] pat(input int e);
        return 14'((e * 197) ^ (e >> 3) ^ 'h2a5);
    endfunction

    // Record what is presented at every edge, indexed by edge number
    always @(posedge clk) begin
        if (rst_n) begin
            hv[edge_n % RING] = smp_valid;
            hk[edge_n % RING] = smp_valid && (vcnt % 4 == 0);
            hd[edge_n % RING] = smp_data;
            if (smp_valid) vcnt++;
            if (trig && trig_real) trig_edge = edge_n;
            edge_n++;
        end
    end

    // Sample source
    initial begin
        forever begin
            @(negedge clk);
            smp_valid = rst_n && !(gap_mode && (edge_n % 5 == 2));
            smp_data  = pat(edge_n);
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected window contents from the recorded history
    task automatic collect(input int t_end, input int len, input bit dec);
        int n = 0;
        int idx = t_end;
        while (n < len && idx > t_end - RING) begin
            int s;
            s = idx % RING;
            if (dec ? hk[s] : hv[s]) begin
                if (dec) exp_e[len-1-n] = hd[s];
                else     exp_s[len-1-n] = hd[s];
                n++;
            end
            idx--;
        end
    endtask

    // Take one word; called and returning at a falling edge
    task automatic take_word(input bit stall, output logic [15:0] d,
                             output logic w, output logic l);
        int g = 0;
        logic [15:0] d0;
        rd_ready = 1'b0;
        while (!rd_valid && g < 20000) begin
            @(negedge clk);
            g++;
        end
        if (stall) begin
            d0 = rd_data;
            @(negedge clk);
            chk(rd_valid && rd_data == d0, "R9 word held under stall", {15'd0, rd_valid, rd_data},
                {15'd0, 1'b1, d0});
        end
        d = rd_data;
        w = rd_win;
        l = rd_last;
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic run_capture(input int le, input int ls, input int de, input int ds,
                               input bit sen, input bit gaps, input bit stall,
                               input bit extra, input string tag);
        logic [15:0] d;
        logic w;
        logic l;
        int g = 0;
        @(negedge clk);
        cfg_e_len   = 11'(le);
        cfg_s_len   = 10'(ls);
        cfg_e_delay = 16'(de);
        cfg_s_delay = 16'(ds);
        cfg_s_en    = sen;
        gap_mode    = gaps;
        repeat (2 * (4 * le + ls) + 16) @(negedge clk);
        trig_real = 1'b1;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        trig_real = 1'b0;
        chk(busy == 1'b1, {tag, " R8 busy after trigger"}, 32'(busy), 32'd1);
        if (extra) begin
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
        while (!rd_valid && g < 20000) begin
            @(negedge clk);
            g++;
        end
        collect(trig_edge + de, le, 1'b1);
        collect(trig_edge + ds, ls, 1'b0);
        for (int j = 0; j < le; j++) begin
            take_word(stall && (j % 2 == 1), d, w, l);
            chk(d == {2'b00, exp_e[j]} && w == 1'b0 && l == (j == le - 1),
                {tag, " R1 R3 R5 energy word"}, {14'd0, w, l, d},
                {14'd0, 1'b0, 1'(j == le - 1), 2'b00, exp_e[j]});
            if (j == 0) begin
                chk(d[15:14] == 2'b00, {tag, " R6 upper bits zero"}, 32'(d[15:14]), 32'd0);
            end
            if (extra && j == 1) begin
                trig = 1'b1;
                @(negedge clk);
                trig = 1'b0;
            end
        end
        if (sen) begin
            for (int j = 0; j < ls; j++) begin
                take_word(stall && (j % 2 == 0), d, w, l);
                chk(d == {2'b00, exp_s[j]} && w == 1'b1 && l == (j == ls - 1),
                    {tag, " R2 R3 R5 shape word"}, {14'd0, w, l, d},
                    {14'd0, 1'b1, 1'(j == ls - 1), 2'b00, exp_s[j]});
            end
        end
        chk(!busy && !rd_valid, {tag, " R8 idle after last word"}, {30'd0, busy, rd_valid}, 32'd0);
        if (extra) begin
            repeat (10) @(negedge clk);
            chk(!busy && !rd_valid, {tag, " R8 trigger while busy ignored"},
                {30'd0, busy, rd_valid}, 32'd0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R10 busy low in reset", 32'(busy), 32'd0);
        chk(rd_valid == 1'b0, "R10 rd_valid low in reset", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R10 idle after reset",
            {30'd0, busy, rd_valid}, 32'd0);
    endtask

    task automatic t_basic();
        run_capture(16, 8, 20, 5, 1'b1, 1'b0, 1'b0, 1'b0, "basic");
    endtask

    task automatic t_zero_delay();
        run_capture(12, 6, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0, "zero delay R3");
    endtask

    task automatic t_long_delay();
        run_capture(8, 4, 100, 50, 1'b1, 1'b0, 1'b0, 1'b0, "long delay R4");
    endtask

    task automatic t_shape_off();
        run_capture(16, 8, 10, 200, 1'b0, 1'b0, 1'b0, 1'b0, "shape off");
        chk(!busy && !rd_valid && !rd_win, "R7 only energy words then idle",
            {29'd0, busy, rd_valid, rd_win}, 32'd0);
    endtask

    task automatic t_gaps_stall();
        run_capture(20, 10, 15, 25, 1'b1, 1'b1, 1'b1, 1'b0, "gaps and stall R9");
        gap_mode = 1'b0;
    endtask

    task automatic t_busy_trig();
        run_capture(16, 8, 40, 30, 1'b1, 1'b0, 1'b0, 1'b1, "retrigger");
    endtask

    task automatic t_full_len();
        run_capture(256, 512, 300, 100, 1'b1, 1'b0, 1'b0, 1'b0, "full shape depth R2");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog R8 run did not finish actual=%0d expected=%0d", edge_n, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_zero_delay();
        t_long_delay();
        t_shape_off();
        t_gaps_stall();
        t_busy_trig();
        t_full_len();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule